// File: doc/BRIEF.md
# Selectable Message Timestamp Counter

This block keeps a 16-bit timestamp for a CAN FD controller. One counter is shared by two time bases. The first is driven by nominal (arbitration-rate) bit ticks from the protocol engine, divided by a small prescaler. The second is driven by the block clock through a divider whose length is a multiple of eight. A 2-bit source code in the configuration register selects the time base, or keeps the counter parked at zero.

Software reaches the block through a simple write port and a combinational read port. The port has four word addresses: configuration, clock divider, counter, and wrap flag. Writing the divider register restarts both the divider and the count. Writing any value to the counter register clears it.

When a frame is received, the protocol engine pulses a capture strobe and the current count is latched for storage with the message. A sticky flag records every wrap of the counter from its maximum back to zero, so that software can extend the timestamp beyond 16 bits.

Top module: `ts_counter_top`

## Requirements
- R1: Configuration word at address 0 holds the source code in bits [1:0] and the prescaler in bits [5:2]. Source code 01 selects bit-time counting and 10 selects clock counting. Codes 00 and 11 hold the counter at zero.
- R2: In bit-time mode the counter advances once every (prescaler+1) nominal bit ticks.
- R3: Data-phase bit ticks (`dataBitTick`) never advance the counter in any mode.
- R4: In clock mode the counter advances once every (divider x 8) clock cycles. The divider is bits [7:0] of address 1, and the value 0 acts as 1. With the reset divider of 2, this gives one step per 16 cycles.
- R5: Any write to address 1 clears the counter and restarts the divider phase from zero.
- R6: Any write to address 2 clears the counter to zero, whatever the data. Reading address 2 returns the count.
- R7: A step from 0xFFFF to 0x0000 sets the sticky wrap flag. The flag is read at address 3 bit 0 and drives `wrapIrq`.
- R8: Writing 1 to bit 0 of address 3 clears the wrap flag. If a wrap occurs in the same cycle as that write, the flag stays set.
- R9: A capture strobe latches the counter value, and `capValue` shows it after the next clock edge. If a step happens in the same cycle as the strobe, the value latched is the one before that step.
- R10: After reset, the configuration reads 0, the divider reads 2, and the counter, wrap flag and captured value are all 0.
- R11: A write to address 0 restarts the prescaler and divider phase from zero. It does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the clock-mode time base |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Combinational read data |
| nomBitTick | input | 1 | One pulse per nominal bit time |
| dataBitTick | input | 1 | One pulse per data-phase bit time (ignored) |
| captureStb | input | 1 | Capture the count for a received frame |
| capValue | output | 16 | Last captured count |
| wrapIrq | output | 1 | Sticky wrap flag |

## Verification
The hardest case to reach is the wrap. The counter cannot be loaded, so it has to be walked through all 65536 values. The stimulus does this with the fastest setting, bit-time mode with prescaler 0 and a nominal tick on every cycle. It then times a flag-clear write to land on the very cycle the counter rolls over, so that set and clear collide. Random runs mix source codes, small dividers, both tick kinds, captures and clearing writes against a per-cycle model of the requirements.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam logic [1:0] SRC_BIT  = 2'b01;
  localparam logic [1:0] SRC_CLK  = 2'b10;
  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_DIV = 2'd1;
  localparam logic [1:0] ADDR_CNT = 2'd2;
  localparam logic [1:0] ADDR_WRP = 2'd3;

  typedef struct packed {
    logic inc;
    logic clr;
    logic hold;
    logic wrapClr;
    logic capture;
  } tsStrobe_t;
endpackage

// File: rtl/ts_ctrl.sv
module ts_ctrl
  import ts_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PRE_W     = 4,
  parameter int DIV_W     = 8,
  parameter int DIV_SHIFT = 3,
  parameter int DIV_RST   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              nomBitTick,
  input  logic              captureStb,
  output logic [1:0]        cfgSrc,
  output logic [PRE_W-1:0]  cfgPre,
  output logic [DIV_W-1:0]  divVal,
  output tsStrobe_t         strobe
);
  localparam int DIVF_W = DIV_W + DIV_SHIFT;
  localparam int PH_W   = (PRE_W > DIVF_W) ? PRE_W : DIVF_W;

  logic [PH_W-1:0]  phase, phNext, divTerm;
  logic [DIV_W-1:0] divEff;
  logic             wrCfg, wrDiv, wrCnt, wrWrp, inc;
  logic             unusedData;

  assign unusedData = ^wrData;
  assign wrCfg = wrEn && (wrAddr == ADDR_CFG);
  assign wrDiv = wrEn && (wrAddr == ADDR_DIV);
  assign wrCnt = wrEn && (wrAddr == ADDR_CNT);
  assign wrWrp = wrEn && (wrAddr == ADDR_WRP);

  assign divEff  = (divVal == '0) ? DIV_W'(1) : divVal;
  assign divTerm = PH_W'({divEff, {DIV_SHIFT{1'b0}}}) - PH_W'(1);

  always_comb begin
    inc    = 1'b0;
    phNext = phase;
    case (cfgSrc)
      SRC_BIT: begin
        if (nomBitTick) begin
          if (phase == PH_W'(cfgPre)) begin
            inc    = 1'b1;
            phNext = '0;
          end else begin
            phNext = phase + PH_W'(1);
          end
        end
      end
      SRC_CLK: begin
        if (phase == divTerm) begin
          inc    = 1'b1;
          phNext = '0;
        end else begin
          phNext = phase + PH_W'(1);
        end
      end
      default: phNext = '0;
    endcase
    if (wrCfg || wrDiv) phNext = '0;
  end

  always_comb begin
    strobe.inc     = inc;
    strobe.clr     = wrDiv || wrCnt;
    strobe.hold    = !((cfgSrc == SRC_BIT) || (cfgSrc == SRC_CLK));
    strobe.wrapClr = wrWrp && wrData[0];
    strobe.capture = captureStb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgSrc <= '0;
      cfgPre <= '0;
      divVal <= DIV_W'(DIV_RST);
      phase  <= '0;
    end else begin
      phase <= phNext;
      if (wrCfg) begin
        cfgSrc <= wrData[1:0];
        cfgPre <= wrData[PRE_W+1:2];
      end
      if (wrDiv) divVal <= wrData[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/ts_datapath.sv
module ts_datapath
  import ts_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tsStrobe_t        strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] capValue,
  output logic             wrapIrq
);
  logic wrapSet;

  assign wrapSet = strobe.inc && !strobe.clr && !strobe.hold && (cntVal == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cntVal   <= '0;
      capValue <= '0;
      wrapIrq  <= 1'b0;
    end else begin
      if (strobe.clr || strobe.hold) cntVal <= '0;
      else if (strobe.inc)           cntVal <= cntVal + CNT_W'(1);
      if (strobe.capture) capValue <= cntVal;
      if (wrapSet)             wrapIrq <= 1'b1;
      else if (strobe.wrapClr) wrapIrq <= 1'b0;
    end
  end
endmodule

// File: rtl/ts_counter_top.sv
module ts_counter_top
  import ts_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 16,
  parameter int PRE_W     = 4,
  parameter int DIV_W     = 8,
  parameter int DIV_SHIFT = 3,
  parameter int DIV_RST   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              nomBitTick,
  input  logic              dataBitTick,
  input  logic              captureStb,
  output logic [CNT_W-1:0]  capValue,
  output logic              wrapIrq
);
  logic [1:0]       cfgSrc;
  logic [PRE_W-1:0] cfgPre;
  logic [DIV_W-1:0] divVal;
  logic [CNT_W-1:0] cntVal;
  tsStrobe_t        strobe;
  logic             unusedTick;

  assign unusedTick = dataBitTick;

  ts_ctrl #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .DIV_W(DIV_W),
    .DIV_SHIFT(DIV_SHIFT), .DIV_RST(DIV_RST)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .nomBitTick(nomBitTick), .captureStb(captureStb),
    .cfgSrc(cfgSrc), .cfgPre(cfgPre), .divVal(divVal), .strobe(strobe)
  );

  ts_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .cntVal(cntVal), .capValue(capValue), .wrapIrq(wrapIrq)
  );

  always_comb begin
    case (rdAddr)
      ADDR_CFG: rdData = DATA_W'({cfgPre, cfgSrc});
      ADDR_DIV: rdData = DATA_W'(divVal);
      ADDR_CNT: rdData = DATA_W'(cntVal);
      default:  rdData = DATA_W'(wrapIrq);
    endcase
  end
endmodule

// File: rtl/ts_counter_chk.sv
module ts_counter_chk
  import ts_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              nomBitTick,
  input logic              captureStb,
  input logic [1:0]        cfgSrc,
  input tsStrobe_t         strobe,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  capValue,
  input logic              wrapIrq
);
  p_held_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !((cfgSrc == SRC_BIT) || (cfgSrc == SRC_CLK)) |=> (cntVal == '0));

  p_no_data_step_r3: assert property (@(posedge clk) disable iff (rst)
    ((cfgSrc == SRC_BIT) && !nomBitTick && !wrEn) |=> $stable(cntVal));

  p_div_write_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrAddr == ADDR_DIV)) |=> (cntVal == '0));

  p_cnt_write_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrAddr == ADDR_CNT)) |=> (cntVal == '0));

  p_wrap_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.inc && !strobe.clr && !strobe.hold && (cntVal == '1)) |=> wrapIrq);

  p_wrap_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (wrapIrq && !(wrEn && (wrAddr == ADDR_WRP) && wrData[0])) |=> wrapIrq);

  p_capture_old_r9: assert property (@(posedge clk) disable iff (rst)
    captureStb |=> (capValue == $past(cntVal)));
endmodule

bind ts_counter_top ts_counter_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .nomBitTick(nomBitTick), .captureStb(captureStb), .cfgSrc(cfgSrc),
  .strobe(strobe), .cntVal(cntVal), .capValue(capValue), .wrapIrq(wrapIrq)
);

// File: tb/ts_counter_top_tb_top.sv
`timescale 1ns/1ps
module ts_counter_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = 2'd2;
  logic [15:0] rdData;
  logic        nomBitTick = 1'b0;
  logic        dataBitTick = 1'b0;
  logic        captureStb = 1'b0;
  logic [15:0] capValue;
  logic        wrapIrq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ts_counter_top dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .nomBitTick(nomBitTick),
    .dataBitTick(dataBitTick), .captureStb(captureStb),
    .capValue(capValue), .wrapIrq(wrapIrq)
  );

  // Requirement model, stepped on each rising edge
  logic [1:0]  mSrc;
  logic [3:0]  mPre;
  logic [7:0]  mDiv;
  int          mPh;
  logic [15:0] mCnt, mCap;
  logic        mWrap;

  function automatic int divTerm(logic [7:0] d);
    return ((d == 8'd0) ? 1 : int'(d)) * 8 - 1;
  endfunction

  always @(posedge clk) begin : mdl
    bit inc, wset;
    int nph;
    if (rst) begin
      mSrc <= 2'd0; mPre <= 4'd0; mDiv <= 8'd2; mPh <= 0;
      mCnt <= 16'd0; mCap <= 16'd0; mWrap <= 1'b0;
    end else begin
      inc = 1'b0; wset = 1'b0; nph = mPh;
      if (mSrc == 2'd1) begin
        if (nomBitTick) begin
          if (mPh == int'(mPre)) begin inc = 1'b1; nph = 0; end
          else nph = mPh + 1;
        end
      end else if (mSrc == 2'd2) begin
        if (mPh == divTerm(mDiv)) begin inc = 1'b1; nph = 0; end
        else nph = mPh + 1;
      end else nph = 0;
      if (captureStb) mCap <= mCnt;
      if ((wrEn && (wrAddr == 2'd1 || wrAddr == 2'd2)) || !(mSrc == 2'd1 || mSrc == 2'd2))
        mCnt <= 16'd0;
      else if (inc) begin
        mCnt <= mCnt + 16'd1;
        if (mCnt == 16'hFFFF) wset = 1'b1;
      end
      if (wset) mWrap <= 1'b1;
      else if (wrEn && wrAddr == 2'd3 && wrData[0]) mWrap <= 1'b0;
      if (wrEn && wrAddr == 2'd0) begin
        mSrc <= wrData[1:0]; mPre <= wrData[5:2]; nph = 0;
      end
      if (wrEn && wrAddr == 2'd1) begin
        mDiv <= wrData[7:0]; nph = 0;
      end
      mPh <= nph;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic runTicks(int n, bit nom, bit dat);
    nomBitTick = nom; dataBitTick = dat;
    for (int i = 0; i < n; i++) tick();
    nomBitTick = 1'b0; dataBitTick = 1'b0;
  endtask

  task automatic readCnt(string tag, logic [15:0] exp);
    logic [15:0] v;
    rd(2'd2, v);
    chk(tag, v, exp);
  endtask

  initial begin : wdog
    #(200000 * 8);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    void'($urandom(32'h1234_5678));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R10 reset state
    rd(2'd0, v); chk("R10 cfg", v, 16'h0000);
    rd(2'd1, v); chk("R10 div", v, 16'h0002);
    rd(2'd2, v); chk("R10 cnt", v, 16'h0000);
    rd(2'd3, v); chk("R10 wrap", v, 16'h0000);
    chk("R10 cap", capValue, 16'h0000);
    // R1 held at zero with code 00 and code 11
    runTicks(20, 1'b1, 1'b1);
    readCnt("R1 src00", 16'd0);
    wr(2'd0, 16'h0003);
    repeat (40) tick();
    readCnt("R1 src11", 16'd0);
    // R4 clock mode, reset divider 2 -> one step per 16 cycles
    wr(2'd1, 16'h0002);
    wr(2'd0, 16'h0002);
    repeat (15) tick();
    readCnt("R4 div16 before", 16'd0);
    tick();
    readCnt("R4 div16 step", 16'd1);
    // R5 divider write clears, R4 divider 0 acts as 1 -> 8 cycles
    wr(2'd1, 16'h0000);
    readCnt("R5 div write clears", 16'd0);
    repeat (7) tick();
    readCnt("R4 div0 before", 16'd0);
    tick();
    readCnt("R4 div0 step", 16'd1);
    // R11 config write restarts phase without clearing count
    repeat (4) tick();
    wr(2'd0, 16'h0002);
    readCnt("R11 count kept", 16'd1);
    repeat (7) tick();
    readCnt("R11 phase restart", 16'd1);
    tick();
    readCnt("R11 step after 8", 16'd2);
    // R3 data ticks ignored in bit mode; R6 counter write clears
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'hBEEF);
    readCnt("R6 counter write clears", 16'd0);
    runTicks(10, 1'b0, 1'b1);
    readCnt("R3 data ticks ignored", 16'd0);
    runTicks(5, 1'b1, 1'b0);
    readCnt("R2 prescale 0", 16'd5);
    // R2 prescaler 3 -> one step per 4 nominal ticks
    wr(2'd0, 16'h000D);
    wr(2'd2, 16'h0000);
    runTicks(11, 1'b1, 1'b1);
    readCnt("R2 prescale 3 partial", 16'd2);
    runTicks(1, 1'b1, 1'b0);
    readCnt("R2 prescale 3", 16'd3);
    // R9 capture coinciding with a step returns the old value
    wr(2'd0, 16'h0001);
    nomBitTick = 1'b1; captureStb = 1'b1;
    tick();
    nomBitTick = 1'b0; captureStb = 1'b0;
    chk("R9 capture old", capValue, 16'd3);
    readCnt("R9 count stepped", 16'd4);
    // Random phase against the model
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      nomBitTick  = ($urandom_range(0, 2) == 0);
      dataBitTick = ($urandom_range(0, 1) == 0);
      captureStb  = ($urandom_range(0, 7) == 0);
      wrEn = 1'b0;
      if (r < 3) begin
        wrEn = 1'b1; wrAddr = 2'd0;
        wrData = {10'd0, 4'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      end else if (r < 5) begin
        wrEn = 1'b1; wrAddr = 2'd1; wrData = 16'($urandom_range(0, 3));
      end else if (r < 6) begin
        wrEn = 1'b1; wrAddr = 2'd2; wrData = 16'($urandom);
      end else if (r < 7) begin
        wrEn = 1'b1; wrAddr = 2'd3; wrData = 16'($urandom);
      end
      tick();
      readCnt("R2 R4 random count", mCnt);
      chk("R9 random capture", capValue, mCap);
      chk("R7 random wrap", {15'd0, wrapIrq}, {15'd0, mWrap});
    end
    wrEn = 1'b0; nomBitTick = 1'b0; dataBitTick = 1'b0; captureStb = 1'b0;
    // R7 / R8 full wrap with coincident clear
    wr(2'd3, 16'h0001);
    chk("R8 clear", {15'd0, wrapIrq}, 16'd0);
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h0000);
    runTicks(65535, 1'b1, 1'b0);
    readCnt("R7 at max", 16'hFFFF);
    chk("R7 no flag before wrap", {15'd0, wrapIrq}, 16'd0);
    nomBitTick = 1'b1;
    wr(2'd3, 16'h0001);
    nomBitTick = 1'b0;
    readCnt("R7 wrapped to zero", 16'd0);
    chk("R8 wrap wins over clear", {15'd0, wrapIrq}, 16'd1);
    repeat (3) tick();
    rd(2'd3, v); chk("R7 sticky", v, 16'd1);
    wr(2'd3, 16'h0000);
    chk("R8 write 0 keeps flag", {15'd0, wrapIrq}, 16'd1);
    wr(2'd3, 16'h0001);
    rd(2'd3, v); chk("R8 write 1 clears", v, 16'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule